// File: doc/BRIEF.md
# Quad-Channel Serial Converter Code Loader

This block is the digital front end of a four-channel, 12-bit digital-to-analog converter. A host sends a 48-bit frame one bit at a time on a serial data pin. Each falling edge of a serial clock pin shifts one bit into a 48-bit shift register. The register's last stage drives a serial output pin, so a second device can be chained on the same bit stream. Each channel has a 12-bit slice of the shift register and a holding register. The holding register drives that channel's output code.

Each channel has its own active-low latch pin. While a latch pin is low, the channel's holding register follows its slice of the shift register. When the pin returns high, the holding register keeps its value. The four latch pins can be strobed one at a time, or tied together so that all channels update in the same cycle.

An active-low clear pin has priority over everything else. It empties the shift register and sets every holding register to mid-scale. A latch strobe that follows a clear therefore commits a zero code. All logic runs on one system clock. The serial pins are resynchronised to that clock, and falling edges of the serial clock are detected from the synchronised samples.

Top module: `quad_dac_front`

## Requirements
- R1: After system reset, all four channel codes are 0x800 and the serial output is 0.
- R2: The shift register moves one position for each falling edge of the serial clock. A rising edge of the serial clock does not move it.
- R3: The first bit shifted in ends up as the MSB of channel D. After 48 falling edges, the shift register holds, MSB first, channel D in bits 47:36, then C in bits 35:24, then B in bits 23:12, and A in bits 11:0.
- R4: While a channel's latch pin (bit 0 = A, bit 3 = D) is low, that channel's code follows its slice of the shift register, including while bits are still being shifted in.
- R5: While a channel's latch pin is high, that channel's code does not change, even when new frames are shifted in.
- R6: A strobe on one latch pin changes only that channel's code.
- R7: Driving all four latch pins low together loads all four slices in the same cycle.
- R8: The serial output is the last stage of the shift register. It shows each input bit 48 falling edges after that bit was shifted in.
- R9: While clear is low, the shift register is all zeros, so the serial output is 0, and every channel code is 0x800.
- R10: A latch strobe given after a clear loads 0x000 into that channel.
- R11: While clear is low, serial clock edges and latch strobes have no effect.
- R12: With separate latch strobes, each group of 12 new bits can be committed to channel A as soon as the 12th bit has been shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low system reset |
| sclkIn | input | 1 | Serial clock; data is taken on its falling edge |
| sdiIn | input | 1 | Serial data in |
| latchNIn | input | 4 | Active-low latch pins, bit 0 = A to bit 3 = D |
| clrNIn | input | 1 | Active-low clear, level-sensitive |
| sdoOut | output | 1 | Serial data out (last shift stage) |
| codeA | output | 12 | Channel A holding-register code |
| codeB | output | 12 | Channel B holding-register code |
| codeC | output | 12 | Channel C holding-register code |
| codeD | output | 12 | Channel D holding-register code |

## Verification
Each pin passes through two synchroniser stages. A falling edge on the serial clock pin therefore moves the shift register, and the serial output with it, on the third system clock edge after the pin changes. A latch or clear pin changes the holding registers on the third edge after it changes. A slice that moves while its latch pin is low reaches the output one edge after the shift register moves. The driver holds every pin level for at least four system cycles and then waits three or more cycles before it pushes an expected value. The monitor compares the outputs on falling system-clock edges, after every path above has settled.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int NUM_CH = 4;

  typedef struct packed {
    logic              shiftEn;
    logic              clearAll;
    logic [NUM_CH-1:0] loadEn;
  } dacStrobe_t;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1 <= RST_VAL;
      dout   <= RST_VAL;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/dacfe_ctrl.sv
module dacfe_ctrl
  import dacfe_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkS,
  input  logic [NUM_CH-1:0] latchNS,
  input  logic              clrNS,
  output dacStrobe_t        strb
);
  logic sclkPrev;
  logic fallSeen;

  always_ff @(posedge clk) begin
    if (!rstN) sclkPrev <= 1'b1;
    else       sclkPrev <= sclkS;
  end

  assign fallSeen = sclkPrev & ~sclkS;

  always_comb begin
    strb.clearAll = ~clrNS;
    strb.shiftEn  = fallSeen & clrNS;
    strb.loadEn   = ~latchNS & {NUM_CH{clrNS}};
  end

  // R2
  single_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftEn |=> !strb.shiftEn);

  // R2
  rise_noshift_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclkS && !sclkPrev) |-> !strb.shiftEn);
endmodule

// File: rtl/dacfe_datapath.sv
module dacfe_datapath
  import dacfe_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  dacStrobe_t                     strb,
  input  logic                           sdiS,
  output logic                           sdoBit,
  output logic [NUM_CH-1:0][CODE_W-1:0]  holdBus
);
  localparam int SHIFT_W = NUM_CH * CODE_W;
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  logic [SHIFT_W-1:0] shiftReg;
  logic [CODE_W-1:0]  holdReg [NUM_CH];

  always_ff @(posedge clk) begin
    if (!rstN || strb.clearAll)
      shiftReg <= '0;
    else if (strb.shiftEn)
      shiftReg <= {shiftReg[SHIFT_W-2:0], sdiS};
  end

  assign sdoBit = shiftReg[SHIFT_W-1];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN || strb.clearAll)
        holdReg[g] <= MID_CODE;
      else if (strb.loadEn[g])
        holdReg[g] <= shiftReg[g*CODE_W +: CODE_W];
    end

    assign holdBus[g] = holdReg[g];

    // R5
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.loadEn[g] && !strb.clearAll) |=> $stable(holdReg[g]));

    // R4
    load_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.loadEn[g] && !strb.clearAll) |=> holdReg[g] == $past(shiftReg[g*CODE_W +: CODE_W]));

    // R9
    clear_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.clearAll |=> holdReg[g] == MID_CODE);
  end

  // R9
  clear_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> (shiftReg == '0 && !sdoBit));

  // R2
  shift_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.shiftEn && !strb.clearAll) |=> $stable(shiftReg));

  // R8
  shift_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shiftEn && !strb.clearAll) |=> sdoBit == $past(shiftReg[SHIFT_W-2]));
endmodule

// File: rtl/quad_dac_front.sv
module quad_dac_front
  import dacfe_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              sdiIn,
  input  logic [3:0]        latchNIn,
  input  logic              clrNIn,
  output logic              sdoOut,
  output logic [CODE_W-1:0] codeA,
  output logic [CODE_W-1:0] codeB,
  output logic [CODE_W-1:0] codeC,
  output logic [CODE_W-1:0] codeD
);
  localparam int SYNC_W = NUM_CH + 3;

  logic [SYNC_W-1:0] pinsRaw;
  logic [SYNC_W-1:0] pinsSync;
  dacStrobe_t        strb;
  logic [NUM_CH-1:0][CODE_W-1:0] holdBus;

  assign pinsRaw = {clrNIn, latchNIn, sclkIn, sdiIn};

  dacfe_sync #(
    .W       (SYNC_W),
    .RST_VAL ({1'b1, {NUM_CH{1'b1}}, 1'b1, 1'b0})
  ) sync_i (
    .clk  (clk),
    .rstN (rstN),
    .din  (pinsRaw),
    .dout (pinsSync)
  );

  dacfe_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .sclkS   (pinsSync[1]),
    .latchNS (pinsSync[NUM_CH+1:2]),
    .clrNS   (pinsSync[SYNC_W-1]),
    .strb    (strb)
  );

  dacfe_datapath #(.CODE_W(CODE_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .sdiS    (pinsSync[0]),
    .sdoBit  (sdoOut),
    .holdBus (holdBus)
  );

  assign codeA = holdBus[0];
  assign codeB = holdBus[1];
  assign codeC = holdBus[2];
  assign codeD = holdBus[3];
endmodule

// File: tb/quad_dac_front_tb_top.sv
module quad_dac_front_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclkIn = 1'b1;
  logic        sdiIn = 1'b0;
  logic [3:0]  latchNIn = 4'hF;
  logic        clrNIn = 1'b1;
  logic        sdoOut;
  logic [11:0] codeA, codeB, codeC, codeD;

  always #5 clk = ~clk;

  quad_dac_front dut_i (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .sdiIn(sdiIn),
    .latchNIn(latchNIn), .clrNIn(clrNIn), .sdoOut(sdoOut),
    .codeA(codeA), .codeB(codeB), .codeC(codeC), .codeD(codeD)
  );

  typedef struct {
    int          kind;
    logic [11:0] exp;
    string       req;
  } item_t;

  item_t       expQ[$];
  int          checks = 0;
  int          failures = 0;
  bit          finished = 0;
  logic [47:0] model = '0;
  logic [11:0] modelHold [4];

  // monitor: kind 0..3 is channel A..D, kind 4 is the serial output
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      item_t it;
      logic [11:0] act;
      it = expQ.pop_front();
      case (it.kind)
        0: act = codeA;
        1: act = codeB;
        2: act = codeC;
        3: act = codeD;
        default: act = {11'd0, sdoOut};
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_item(input int kind, input logic [11:0] val, input string req);
    item_t it;
    it.kind = kind; it.exp = val; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic expect_all(input string req);
    for (int c = 0; c < 4; c++) expect_item(c, modelHold[c], req);
  endtask

  task automatic shift_bit(input logic b, input bit track, input bit chkSdo);
    sdiIn = b;
    tick(4);
    sclkIn = 1'b0;
    tick(4);
    sclkIn = 1'b1;
    tick(3);
    if (track) model = {model[46:0], b};
    if (chkSdo) expect_item(4, {11'd0, model[47]}, "R8");
  endtask

  task automatic shift_word(input logic [11:0] w, input bit chkSdo);
    for (int i = 11; i >= 0; i--) shift_bit(w[i], 1'b1, chkSdo);
  endtask

  task automatic strobe(input logic [3:0] mask);
    latchNIn = ~mask;
    tick(6);
    for (int c = 0; c < 4; c++)
      if (mask[c]) modelHold[c] = model[c*12 +: 12];
    latchNIn = 4'hF;
    tick(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [11:0] w [4];
    logic [11:0] f1 [4];
    for (int c = 0; c < 4; c++) modelHold[c] = 12'h800;
    tick(5);
    rstN = 1'b1;
    tick(6);
    // R1: reset state
    expect_all("R1");
    expect_item(4, 12'h000, "R1");
    tick(2);

    // R3 R7 R8: first frame, D word first, all latches together
    for (int c = 0; c < 4; c++) f1[c] = 12'($urandom);
    for (int c = 3; c >= 0; c--) shift_word(f1[c], 1'b1);
    strobe(4'hF);
    for (int c = 0; c < 4; c++) expect_item(c, f1[c], "R3_R7");
    tick(2);

    // R5 R8: second frame with latches high; serial out replays first frame
    for (int c = 0; c < 4; c++) w[c] = 12'($urandom);
    for (int c = 3; c >= 0; c--) shift_word(w[c], 1'b1);
    expect_all("R5");
    tick(2);

    // R6: only B updates
    strobe(4'b0010);
    expect_item(1, w[1], "R6");
    expect_all("R6");
    tick(2);

    // R4: C held low while 12 more bits arrive; C follows moving slice
    latchNIn = 4'b1011;
    tick(6);
    expect_item(2, w[2], "R4");
    shift_word(12'($urandom), 1'b1);
    tick(3);
    modelHold[2] = model[24 +: 12];
    expect_item(2, w[1], "R4");
    latchNIn = 4'hF;
    tick(6);
    shift_word(12'($urandom), 1'b1);
    expect_all("R5");
    tick(2);

    // R12: a new word on channel A every 12 serial clocks
    for (int k = 0; k < 4; k++) begin
      logic [11:0] nw;
      nw = 12'($urandom);
      shift_word(nw, 1'b1);
      strobe(4'b0001);
      expect_item(0, nw, "R12");
    end
    tick(2);

    // R9: clear
    clrNIn = 1'b0;
    tick(6);
    model = '0;
    for (int c = 0; c < 4; c++) modelHold[c] = 12'h800;
    expect_all("R9");
    expect_item(4, 12'h000, "R9");
    tick(2);

    // R11: shifting ones and strobing during clear does nothing
    for (int i = 0; i < 6; i++) shift_bit(1'b1, 1'b0, 1'b0);
    latchNIn = 4'h0;
    tick(6);
    expect_all("R11");
    expect_item(4, 12'h000, "R11");
    tick(2);
    latchNIn = 4'hF;
    tick(6);
    clrNIn = 1'b1;
    tick(6);
    expect_all("R11");
    tick(2);

    // R10: latch after clear loads zero into D only
    strobe(4'b1000);
    expect_item(3, 12'h000, "R10");
    expect_all("R10");
    tick(2);

    // R8: cleared register drains zeros, then a fresh word reaches the output
    for (int c = 0; c < 4; c++) shift_word(12'($urandom), 1'b1);
    shift_word(12'($urandom), 1'b1);
    tick(4);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule